// File: doc/BRIEF.md
# Grouped Secondary Interrupt Controller

This block collects thirty-two interrupt requests from slow peripherals and condenses them for a primary interrupt aggregator. Each request line lands in one bit of a status register. A mask register of the same width decides which pending bits count. Software identifies source bit k as interrupt number 33+k. The block exports the masked pending vector. After the primary has seen a group summary, it can pick the exact source from this vector without a register read.

The sources are split into three fixed groups, and each group drives one summary line. The audio group is bits 0 to 7 and feeds primary input 6. The misc group is bits 8 to 15 and feeds primary input 5. The serial/parallel group is bits 16 to 31 and feeds primary input 4. Most bits are level-sensitive and simply follow their source. Bits 16, 22 and 28 are latches that capture a rising edge and keep it until software clears the bit by writing a zero to it. A simple register port lets software write the status or mask register and read either of them back.

Top module: `slow_irq_group_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears the status register, the mask register, the pending vector and all three summary outputs.
- R2: Each level-sensitive status bit (every bit except 16, 22 and 28) equals its source as sampled at the previous rising clock edge.
- R3: A status write (wr_sel_i = 0) has no effect on level-sensitive bits, whatever the data.
- R4: An edge-latched bit (16, 22 or 28) is set when its source is 1 at a clock edge after having been 0 at the edge before, and it stays set after the source returns to 0.
- R5: A status write with a 0 in an edge-latched position clears that bit at the same edge; a 1 in that position leaves the bit unchanged, so a write never sets a bit.
- R6: When a rising edge and a clearing write to the same edge-latched bit meet at one clock edge, the bit stays set.
- R7: pend_o equals status AND mask, and a mask write affects pend_o from the edge where it is written.
- R8: irq_audio_o is the OR of pend_o bits 0-7, irq_misc_o the OR of bits 8-15, and irq_sio_o the OR of bits 16-31.
- R9: A write with wr_sel_i = 1 loads the mask register. rd_data_o shows the status register when rd_sel_i = 0 and the mask register when rd_sel_i = 1, with no clock delay.
- R10: An edge-latched source that stays high after its bit has been cleared does not set the bit again until it has fallen and risen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Peripheral interrupt request lines, one per source bit |
| wr_en_i | input | 1 | Register write strobe, one clock wide |
| wr_sel_i | input | 1 | Write target: 0 status, 1 mask |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 mask |
| rd_data_o | output | 32 | Selected register value |
| pend_o | output | 32 | Masked pending vector (status AND mask) |
| irq_audio_o | output | 1 | Audio group summary, bits 0-7 |
| irq_misc_o | output | 1 | Misc group summary, bits 8-15 |
| irq_sio_o | output | 1 | Serial/parallel group summary, bits 16-31 |

## Verification
A source edge and a software clear can meet at the same clock edge on an edge-latched bit. The bench provokes this by raising source bit 22 in the cycle where a zero is written to status bit 22. It judges the result by reading status back one edge later and expecting the bit still set. On the next edge the same zero write is repeated while the source stays high, and the bench expects the bit to clear and stay clear.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Number of source bits handled by the controller.
    localparam int unsigned SRC_W = 32;

    // Number of group summary outputs.
    localparam int unsigned GRP_N = 3;

    // Default positions of edge-latched sources: bits 16, 22 and 28.
    localparam logic [SRC_W-1:0] EDGE_POS_DEF = 32'h1041_0000;

    // Register select for the software port.
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // Group index: 0 audio, 1 misc, 2 serial/parallel.
    function automatic int unsigned grp_lo(input int unsigned g);
        case (g)
            0:       return 0;
            1:       return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int unsigned grp_hi(input int unsigned g);
        case (g)
            0:       return 7;
            1:       return 15;
            default: return 31;
        endcase
    endfunction

endpackage

// File: rtl/sirq_capture.sv
module sirq_capture
    import sirq_pkg::*;
#(
    parameter int unsigned     W        = SRC_W,
    parameter logic [W-1:0]    EDGE_POS = EDGE_POS_DEF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] prev;
    } cap_state_t;

    cap_state_t d, q;

    logic [W-1:0] rise_w;
    logic [W-1:0] keep_w;

    always_comb begin
        d      = q;
        // Rising edge: 1 now, 0 at the previous edge.
        rise_w = src_i & ~q.prev;
        // A written 0 clears, a written 1 keeps.
        keep_w = clr_we_i ? clr_data_i : {W{1'b1}};
        d.prev = src_i;
        // Edge positions latch; a rise overrides a clear at the same edge.
        // Level positions follow the source and ignore writes.
        d.status = (EDGE_POS & ((q.status & keep_w) | rise_w))
                 | (~EDGE_POS & src_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.status;

endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg
    import sirq_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (we_i) begin
            mask_d = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/sirq_group_or.sv
module sirq_group_or
    import sirq_pkg::*;
#(
    parameter int unsigned W = SRC_W,
    parameter int unsigned N = GRP_N
) (
    input  logic [W-1:0] pend_i,
    output logic [N-1:0] grp_o
);

    for (genvar g = 0; g < N; g++) begin : g_grp
        localparam int unsigned LO = grp_lo(g);
        localparam int unsigned HI = grp_hi(g);
        assign grp_o[g] = |pend_i[HI:LO];
    end

endmodule

// File: rtl/slow_irq_group_ctrl.sv
module slow_irq_group_ctrl
    import sirq_pkg::*;
#(
    parameter int unsigned  SRC_W_P  = SRC_W,
    parameter logic [SRC_W_P-1:0] EDGE_POS = EDGE_POS_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [SRC_W_P-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [SRC_W_P-1:0] wr_data_i,
    input  logic               rd_sel_i,
    output logic [SRC_W_P-1:0] rd_data_o,
    output logic [SRC_W_P-1:0] pend_o,
    output logic               irq_audio_o,
    output logic               irq_misc_o,
    output logic               irq_sio_o
);

    localparam int unsigned GRP_AUDIO = 0;
    localparam int unsigned GRP_MISC  = 1;
    localparam int unsigned GRP_SIO   = 2;

    logic [SRC_W_P-1:0] status_w;
    logic [SRC_W_P-1:0] mask_w;
    logic [GRP_N-1:0]   grp_w;
    logic               st_we_w;
    logic               mk_we_w;

    assign st_we_w = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS);
    assign mk_we_w = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);

    sirq_capture #(
        .W        (SRC_W_P),
        .EDGE_POS (EDGE_POS)
    ) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .clr_we_i   (st_we_w),
        .clr_data_i (wr_data_i),
        .status_o   (status_w)
    );

    sirq_mask_reg #(
        .W (SRC_W_P)
    ) u_mask (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (mk_we_w),
        .data_i (wr_data_i),
        .mask_o (mask_w)
    );

    assign pend_o = status_w & mask_w;

    sirq_group_or #(
        .W (SRC_W_P),
        .N (GRP_N)
    ) u_grp (
        .pend_i (pend_o),
        .grp_o  (grp_w)
    );

    assign irq_audio_o = grp_w[GRP_AUDIO];
    assign irq_misc_o  = grp_w[GRP_MISC];
    assign irq_sio_o   = grp_w[GRP_SIO];

    always_comb begin
        if (reg_sel_e'(rd_sel_i) == SEL_MASK) begin
            rd_data_o = mask_w;
        end else begin
            rd_data_o = status_w;
        end
    end

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
    import sirq_pkg::*;
#(
    parameter int unsigned  W        = SRC_W,
    parameter logic [W-1:0] EDGE_POS = EDGE_POS_DEF
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] src,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] status,
    input logic [W-1:0] mask
);

    logic         valid_q;
    logic [W-1:0] src_d1_q;
    logic [W-1:0] clr_v;
    logic [W-1:0] rise_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            src_d1_q <= '0;
        end else begin
            valid_q  <= 1'b1;
            src_d1_q <= src;
        end
    end

    assign clr_v  = (wr_en && !wr_sel) ? ~wr_data : '0;
    assign rise_v = src & ~src_d1_q;

    // R2 and R3: level bits mirror the source sampled at the last edge.
    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((status & ~EDGE_POS) == (src_d1_q & ~EDGE_POS)));

    // R4: a latched edge bit only drops when a clearing write targets it.
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> ((($past(status) & EDGE_POS & ~$past(clr_v)) & ~status) == '0));

    // R6: a rise at an edge position always leaves the bit set.
    a_r6_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> (($past(rise_v) & EDGE_POS & ~status) == '0));

    // R5: an edge bit can become set only through a source rise.
    a_r5_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> ((status & EDGE_POS & ~$past(status) & ~$past(rise_v)) == '0));

    // R9: a mask write is visible after the edge.
    a_r9_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (mask == $past(wr_data)));

endmodule

bind slow_irq_group_ctrl sirq_checker #(
    .W        (SRC_W_P),
    .EDGE_POS (EDGE_POS)
) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .src     (src_i),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .status  (status_w),
    .mask    (mask_w)
);

// File: tb/slow_irq_group_ctrl_test.sv
`timescale 1ns/1ps
module slow_irq_group_ctrl_test;

    localparam int NV = 16;

    typedef struct packed {
        logic [31:0] src;
        logic        we;
        logic        sel;
        logic [31:0] wdata;
        logic [31:0] st;
        logic [31:0] pend;
        logic [2:0]  grp;   // {audio, misc, sio}
    } vec_t;

    // Each row: inputs applied before an edge, results expected after it.
    localparam logic [132:0] TBL [NV] = '{
        {32'h0000_0001, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 3'b100}, // R2
        {32'h0000_0A00, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0A00, 32'h0000_0A00, 3'b010}, // R2
        {32'h0001_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0001_0000, 32'h0001_0000, 3'b001}, // R4
        {32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0001_0000, 32'h0001_0000, 3'b001}, // R4
        {32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0001_0000, 3'b001}, // R5
        {32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'b000}, // R5
        {32'h0040_0000, 1'b1, 1'b0, 32'h0000_0000, 32'h0040_0000, 32'h0040_0000, 3'b001}, // R6
        {32'h0040_0000, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'b000}, // R10
        {32'h0040_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'b000}, // R10
        {32'h0000_00FF, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF, 3'b100}, // R3
        {32'h1000_8000, 1'b0, 1'b0, 32'h0000_0000, 32'h1000_8000, 32'h1000_8000, 3'b011}, // R4
        {32'h0000_0000, 1'b1, 1'b1, 32'h0000_00FF, 32'h1000_0000, 32'h0000_0000, 3'b000}, // R9
        {32'h0000_0003, 1'b0, 1'b0, 32'h0000_0000, 32'h1000_0003, 32'h0000_0003, 3'b100}, // R7
        {32'h0000_0080, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h1000_0080, 32'h1000_0080, 3'b101}, // R8
        {32'h0000_0100, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 3'b010}, // R5
        {32'h8000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 3'b001}  // R8
    };

    string tags [NV] = '{"R2", "R2", "R4", "R4", "R5", "R5", "R6", "R10",
                         "R10", "R3", "R4", "R9", "R7", "R8", "R5", "R8"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] pend;
    logic        irq_audio, irq_misc, irq_sio;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    slow_irq_group_ctrl uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .rd_sel_i    (rd_sel),
        .rd_data_o   (rd_data),
        .pend_o      (pend),
        .irq_audio_o (irq_audio),
        .irq_misc_o  (irq_misc),
        .irq_sio_o   (irq_sio)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs, pass one rising edge, settle away from it.
    task automatic step(input logic [31:0] s, input logic we, input logic sel,
                        input logic [31:0] wd);
        src     = s;
        wr_en   = we;
        wr_sel  = sel;
        wr_data = wd;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        // R1: state while reset is held.
        repeat (3) @(posedge clk);
        #1;
        rd_sel = 1'b0;
        chk("R1 status", rd_data, 32'h0);
        chk("R1 pend", pend, 32'h0);
        chk("R1 groups", {29'd0, irq_audio, irq_misc, irq_sio}, 32'h0);
        rd_sel = 1'b1;
        #1;
        chk("R1 mask", rd_data, 32'h0);
        rd_sel = 1'b0;
        rst_n = 1'b1;
        step(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        rd_sel = 1'b1;
        #1;
        chk("R9 mask readback", rd_data, 32'hFFFF_FFFF);
        rd_sel = 1'b0;
        #1;
        chk("R9 status readback", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            v = vec_t'(TBL[i]);
            step(v.src, v.we, v.sel, v.wdata);
            chk({tags[i], " status"}, rd_data, v.st);
            chk("R7 pend", pend, v.pend);
            chk("R8 groups", {29'd0, irq_audio, irq_misc, irq_sio}, {29'd0, v.grp});
        end

        // R9: mask value left by the table, read with no clock.
        rd_sel = 1'b1;
        #1;
        chk("R9 mask select", rd_data, 32'hFFFF_FFFF);
        rd_sel = 1'b0;

        // R1: reset in mid-run clears a latched edge bit and the mask.
        step(32'h0001_0001, 1'b0, 1'b0, 32'h0);
        chk("R4 latch before reset", rd_data, 32'h0001_0001);
        src = 32'h0;
        rst_n = 1'b0;
        #1;
        chk("R1 async status", rd_data, 32'h0);
        chk("R1 async groups", {29'd0, irq_audio, irq_misc, irq_sio}, 32'h0);
        rd_sel = 1'b1;
        #1;
        chk("R1 async mask", rd_data, 32'h0);
        rd_sel = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(32'h0, 1'b0, 1'b0, 32'h0);
        chk("R1 after release", rd_data, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule